// File: doc/BRIEF.md
# Half-Full Triggered FIFO Drain Controller

This block empties an external word FIFO into a linear buffer memory, one fixed-size burst at a time. A burst moves half the FIFO depth. It starts when the FIFO's half-full flag goes from low to high. While a burst runs, the controller does not watch the flag for edges. When a burst ends, it checks the flag level. If the flag is still high and bursts remain, the next burst follows with no gap. If not, it waits for a fresh rising edge. Because of this check, a flag that stays high can never leave the FIFO stuck half full.

Each FIFO word is read with a programmable access cycle: a setup phase, then an active strobe phase, then a hold phase. The chip select stays high for the whole burst. The word present on the FIFO data pins in the last strobe cycle is written to the buffer. Buffer addresses count up from a base address, and each burst continues where the previous one ended. A start pulse loads the burst count, returns the buffer address to its base and arms the edge detector. After the programmed number of bursts, a done flag rises and no further accesses start.

Top module: `hf_drain_ctrl`

## Requirements
- R1: After reset, `fifo_cs`, `fifo_re`, `buf_we` and `done` are low, and half-full edges cause no access until `start` is pulsed. A `start` pulse, accepted in any state but an active burst, clears `done`, sets `buf_addr` to `BUF_BASE` and arms edge detection.
- R2: A burst starts only on a low-to-high transition of the synchronized half-full flag. A flag that is already high when `start` arrives starts nothing.
- R3: Rising edges of the half-full flag during a burst are discarded and never start a later burst.
- R4: When a burst completes with the flag high and bursts remaining, the next burst follows at once. `fifo_cs` stays high and the element period is unbroken.
- R5: When a burst completes with the flag low and bursts remaining, `fifo_cs` falls and the block waits for a new rising edge.
- R6: Each burst writes exactly `FIFO_DEPTH/2` words (128 by default).
- R7: Each word access has `SETUP_CYC` (1) setup cycles, `STROBE_CYC` (4) cycles of `fifo_re` high and `HOLD_CYC` (2) hold cycles, a period of 7 cycles. `fifo_re` is high only while `fifo_cs` is high.
- R8: `buf_we` is a one-cycle pulse in the first hold cycle. `buf_wdata` then equals the value of `fifo_rdata` in the last strobe cycle.
- R9: `buf_addr` advances by one after each write. It runs contiguously across bursts, ending at `BUF_BASE + BURSTS*FIFO_DEPTH/2`.
- R10: `fifo_addr` always equals the parameter `FIFO_LOC`.
- R11: `done` rises after `BURSTS` (8) completed bursts. It then stays high with no further access until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that loads counters and arms the block |
| hf_async | input | 1 | Asynchronous half-full flag from the FIFO |
| fifo_rdata | input | DATA_W | FIFO read data |
| fifo_addr | output | ADDR_W | Fixed FIFO location |
| fifo_cs | output | 1 | FIFO select, high for the whole burst |
| fifo_re | output | 1 | FIFO read strobe, high in the strobe phase |
| buf_addr | output | ADDR_W | Buffer write address |
| buf_wdata | output | DATA_W | Buffer write data |
| buf_we | output | 1 | Buffer write enable, one cycle per word |
| done | output | 1 | High once all bursts have completed |

## Verification
Two events can fall in the same cycle: a burst completing and a change of the half-full flag. The completion logic samples the flag level at the very cycle in which the edge detector would otherwise re-arm. The bench drives each burst from a table. Some rows keep the flag high across completion, some drop it mid-burst, and some pulse it low and high inside the burst. The bench judges each case at the ports: it checks that `fifo_cs` never drops and the 7-cycle period stays intact across a continued boundary, and that the block stays idle with an unchanged write count after a drained one.

// File: rtl/hf_drain_pkg.sv
package hf_drain_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_BUSY  = 2'd2,
      ST_DONE  = 2'd3
   } drain_state_e;

   typedef enum logic [1:0] {
      PH_SETUP  = 2'd0,
      PH_STROBE = 2'd1,
      PH_HOLD   = 2'd2
   } rd_phase_e;

endpackage

// File: rtl/hf_sync_edge.sv
module hf_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic arm,
   output logic level,
   output logic rise
);

   logic [STAGES-1:0] chain_q;
   logic              level_d_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hf_sync_edge: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) level_d_q <= 1'b0;
      else        level_d_q <= chain_q[STAGES-1];
   end

   assign level = chain_q[STAGES-1];
   // edges seen while disarmed are dropped, never held for later (R3)
   assign rise  = arm & level & ~level_d_q;

   a_r2_rise_is_new_high: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> level_d_q);

endmodule

// File: rtl/hf_read_seq.sv
module hf_read_seq
   import hf_drain_pkg::*;
#(
   parameter int unsigned SETUP_CYC  = 1,
   parameter int unsigned STROBE_CYC = 4,
   parameter int unsigned HOLD_CYC   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic strobe,
   output logic capture,
   output logic elem_end
);

   localparam int unsigned CNT_W = $clog2(SETUP_CYC + STROBE_CYC + HOLD_CYC + 1);
   localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] HLD_LAST = CNT_W'(HOLD_CYC - 1);

   generate
      if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_phase
         $error("hf_read_seq: every phase needs at least one cycle");
      end
   endgenerate

   rd_phase_e        phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         phase_q <= PH_SETUP;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_SETUP: begin
               if (cnt_q == SET_LAST) begin
                  phase_q <= PH_STROBE;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            PH_STROBE: begin
               if (cnt_q == STB_LAST) begin
                  phase_q <= PH_HOLD;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            default: begin
               if (cnt_q == HLD_LAST) begin
                  phase_q <= PH_SETUP;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
         endcase
      end
   end

   assign strobe   = run && (phase_q == PH_STROBE);
   assign capture  = strobe && (cnt_q == STB_LAST);
   assign elem_end = run && (phase_q == PH_HOLD) && (cnt_q == HLD_LAST);

   a_r7_strobe_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> $past(run));

endmodule

// File: rtl/hf_drain_ctrl.sv
module hf_drain_ctrl
   import hf_drain_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned FIFO_DEPTH  = 256,
   parameter int unsigned BURSTS      = 8,
   parameter int unsigned ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] FIFO_LOC = '0,
   parameter logic [ADDR_W-1:0] BUF_BASE = '0,
   parameter int unsigned SETUP_CYC   = 1,
   parameter int unsigned STROBE_CYC  = 4,
   parameter int unsigned HOLD_CYC    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              hf_async,
   input  logic [DATA_W-1:0] fifo_rdata,
   output logic [ADDR_W-1:0] fifo_addr,
   output logic              fifo_cs,
   output logic              fifo_re,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_wdata,
   output logic              buf_we,
   output logic              done
);

   localparam int unsigned BURST_LEN = FIFO_DEPTH / 2;
   localparam int unsigned ELEM_W    = $clog2(BURST_LEN + 1);
   localparam int unsigned BURST_W   = $clog2(BURSTS + 1);
   localparam int unsigned RUN_W     = $clog2(STROBE_CYC + 2);

   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH % 2) != 0) begin : g_bad_depth
         $error("hf_drain_ctrl: FIFO_DEPTH must be even and at least 2");
      end
      if (BURSTS < 1) begin : g_bad_bursts
         $error("hf_drain_ctrl: BURSTS must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("hf_drain_ctrl: ADDR_W too small");
      end
   endgenerate

   drain_state_e        state_q;
   logic [BURST_W-1:0]  burst_left_q;
   logic [ELEM_W-1:0]   elem_left_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic                we_q;

   logic hf_level, hf_rise;
   logic busy, strobe, capture, elem_end;
   logic last_elem, last_burst;

   assign busy = (state_q == ST_BUSY);

   hf_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (hf_async),
      .arm      (state_q == ST_ARMED),
      .level    (hf_level),
      .rise     (hf_rise)
   );

   hf_read_seq #(
      .SETUP_CYC  (SETUP_CYC),
      .STROBE_CYC (STROBE_CYC),
      .HOLD_CYC   (HOLD_CYC)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .strobe   (strobe),
      .capture  (capture),
      .elem_end (elem_end)
   );

   assign last_elem  = (elem_left_q == ELEM_W'(1));
   assign last_burst = (burst_left_q == BURST_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         burst_left_q <= '0;
         elem_left_q  <= ELEM_W'(BURST_LEN);
         addr_q       <= BUF_BASE;
         wdata_q      <= '0;
         we_q         <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (we_q) addr_q <= addr_q + 1'b1;
         if (capture) begin
            we_q    <= 1'b1;
            wdata_q <= fifo_rdata;
         end
         unique case (state_q)
            ST_BUSY: begin
               if (elem_end) begin
                  if (last_elem) begin
                     elem_left_q  <= ELEM_W'(BURST_LEN);
                     burst_left_q <= burst_left_q - 1'b1;
                     if (last_burst)    state_q <= ST_DONE;
                     else if (hf_level) state_q <= ST_BUSY;
                     else               state_q <= ST_ARMED;
                  end else begin
                     elem_left_q <= elem_left_q - 1'b1;
                  end
               end
            end
            default: begin
               if (start) begin
                  state_q      <= ST_ARMED;
                  burst_left_q <= BURST_W'(BURSTS);
                  elem_left_q  <= ELEM_W'(BURST_LEN);
                  addr_q       <= BUF_BASE;
               end else if (hf_rise) begin
                  state_q <= ST_BUSY;
               end
            end
         endcase
      end
   end

   assign fifo_addr = FIFO_LOC;
   assign fifo_cs   = busy;
   assign fifo_re   = strobe;
   assign buf_addr  = addr_q;
   assign buf_wdata = wdata_q;
   assign buf_we    = we_q;
   assign done      = (state_q == ST_DONE);

   // independent run-length counter of the read strobe
   logic [RUN_W-1:0] re_run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)       re_run_q <= '0;
      else if (fifo_re) re_run_q <= re_run_q + 1'b1;
      else              re_run_q <= '0;
   end

   a_r7_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fifo_re) |-> (re_run_q == RUN_W'(STROBE_CYC)));

   a_r7_re_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_re |-> fifo_cs);

   a_r8_we_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (fifo_cs && !fifo_re && $past(fifo_re)));

   a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |=> (buf_addr == ($past(buf_addr) + ADDR_W'(1))));

   a_r3_burst_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_cs) |-> $past(hf_rise));

   a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_end && last_elem && !last_burst && hf_level) |=> fifo_cs);

   a_r5_wait_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_end && last_elem && !hf_level) |=> !fifo_cs);

   a_r11_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!fifo_cs && !buf_we));

endmodule

// File: tb/test_hf_drain_ctrl.sv
module test_hf_drain_ctrl;

   localparam int unsigned DATA_W   = 32;
   localparam int unsigned ADDR_W   = 16;
   localparam int unsigned DEPTH    = 256;
   localparam int unsigned BURSTS   = 8;
   localparam int unsigned BLEN     = DEPTH / 2;
   localparam int unsigned SETUP    = 1;
   localparam int unsigned STROBE   = 4;
   localparam int unsigned HOLD     = 2;
   localparam int unsigned PERIOD   = SETUP + STROBE + HOLD;
   localparam logic [ADDR_W-1:0] LOC  = 16'h0040;
   localparam logic [ADDR_W-1:0] BASE = 16'h0200;

   // per burst: {expect_continue, mode}; mode 0 drop mid-burst,
   // 1 hold high through completion, 2 low/high/low pulse inside the burst
   localparam logic [2:0] PLAN [BURSTS] = '{3'b000, 3'b101, 3'b010, 3'b101,
                                            3'b101, 3'b000, 3'b010, 3'b000};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              hf = 1'b0;
   logic [DATA_W-1:0] fifo_rdata;
   logic [ADDR_W-1:0] fifo_addr, buf_addr;
   logic [DATA_W-1:0] buf_wdata;
   logic              fifo_cs, fifo_re, buf_we, done;

   always #2.5 clk = ~clk;

   hf_drain_ctrl #(
      .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH), .BURSTS(BURSTS), .ADDR_W(ADDR_W),
      .FIFO_LOC(LOC), .BUF_BASE(BASE), .SETUP_CYC(SETUP), .STROBE_CYC(STROBE),
      .HOLD_CYC(HOLD), .SYNC_STAGES(2)
   ) i_hf_drain_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .hf_async(hf),
      .fifo_rdata(fifo_rdata), .fifo_addr(fifo_addr), .fifo_cs(fifo_cs),
      .fifo_re(fifo_re), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .buf_we(buf_we), .done(done)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // port monitor and FIFO model, sampled on the falling edge
   int wr_total = 0;
   int cs_falls = 0;
   int re_run = 0, post = 0, gap = 0, cs_cyc = 0, k = 0;
   bit first = 1'b1, re_p = 1'b0, cs_p = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         wr_total = 0; re_run = 0; post = 0; gap = 0; cs_cyc = 0; k = 0;
         first = 1'b1; re_p = 1'b0; cs_p = 1'b0;
         fifo_rdata <= '0;
      end else begin
         if (start) wr_total = 0;
         if (fifo_re && !fifo_cs) check(1'b0, "R7", "re without cs", 1, 0);
         if (buf_we) begin
            check(re_p && !fifo_re, "R8", "we not in first hold", fifo_re, 0);
            check(buf_wdata == {wr_total[23:0], 8'(STROBE - 1)}, "R8", "wdata",
                  buf_wdata, {wr_total[23:0], 8'(STROBE - 1)});
            check(buf_addr == BASE + ADDR_W'(wr_total), "R9", "addr",
                  buf_addr, BASE + ADDR_W'(wr_total));
            wr_total++;
         end
         if (fifo_re) re_run++;
         else if (re_p) begin
            check(re_run == STROBE, "R7", "strobe width", re_run, STROBE);
            re_run = 0;
            post = 1;
         end else if (fifo_cs) post++;
         if (fifo_re && !re_p) begin
            if (first) check(cs_cyc == SETUP, "R7", "setup", cs_cyc, SETUP);
            else       check(gap == PERIOD, "R7", "period", gap, PERIOD);
            first = 1'b0;
            gap = 0;
         end
         gap++;
         if (cs_p && !fifo_cs) begin
            check(post == HOLD, "R7", "hold", post, HOLD);
            cs_falls++;
         end
         if (fifo_cs) cs_cyc++;
         else begin cs_cyc = 0; first = 1'b1; end
         if (fifo_re) begin
            fifo_rdata <= {wr_total[23:0], 8'(k)};
            k++;
         end else begin
            k = 0;
            fifo_rdata <= 32'hDEAD_BEEF;
         end
         re_p = fifo_re;
         cs_p = fifo_cs;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_writes(input int n);
      while (wr_total < n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_start;
      start = 1'b1;
      tick(1);
      start = 1'b0;
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int falls0;
      int target;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state, R10 fixed FIFO location
      check(!fifo_cs && !fifo_re && !buf_we, "R1", "idle outputs", fifo_cs, 0);
      check(!done, "R1", "done after reset", done, 0);
      check(fifo_addr == LOC, "R10", "fifo_addr", fifo_addr, LOC);
      // R1 edge before start is ignored
      hf = 1'b1;
      tick(30);
      check(!fifo_cs, "R1", "edge before start", fifo_cs, 0);
      hf = 1'b0;
      tick(10);
      // R2 level already high at start does not trigger
      hf = 1'b1;
      tick(5);
      pulse_start();
      tick(30);
      check(!fifo_cs, "R2", "level without edge", fifo_cs, 0);
      check(buf_addr == BASE, "R1", "base after start", buf_addr, BASE);
      hf = 1'b0;
      tick(10);

      for (int b = 0; b < int'(BURSTS); b++) begin
         logic [1:0] mode;
         bit         exp_cont;
         mode     = PLAN[b][1:0];
         exp_cont = PLAN[b][2];
         falls0   = cs_falls;
         target   = (b + 1) * int'(BLEN);
         if (!hf) hf = 1'b1;
         if (mode == 2'd2) begin
            wait_writes(b * int'(BLEN) + 10);  hf = 1'b0;
            wait_writes(b * int'(BLEN) + 20);  hf = 1'b1;
            wait_writes(b * int'(BLEN) + 40);  hf = 1'b0;
         end else if (mode == 2'd0) begin
            wait_writes(b * int'(BLEN) + 20);  hf = 1'b0;
         end
         wait_writes(target);
         check(cs_falls == falls0, "R6", "cs dropped inside burst", cs_falls, falls0);
         tick(40);
         if (b == int'(BURSTS) - 1) begin
            check(done, "R11", "done after last burst", done, 1);
            check(wr_total == target, "R6", "final word count", wr_total, target);
         end else if (exp_cont) begin
            check(fifo_cs, "R4", "continued burst", fifo_cs, 1);
            check(cs_falls == falls0, "R4", "gap at boundary", cs_falls, falls0);
            check(wr_total > target, "R4", "writes continue", wr_total, target + 1);
         end else begin
            check(!fifo_cs, "R5", "idle after drain", fifo_cs, 0);
            check(wr_total == target, mode == 2'd2 ? "R3" : "R5", "no extra burst",
                  wr_total, target);
            check(!done, "R11", "done early", done, 0);
         end
      end

      check(buf_addr == BASE + ADDR_W'(BURSTS * BLEN), "R9", "final address",
            buf_addr, BASE + ADDR_W'(BURSTS * BLEN));
      // R11 no access after done
      hf = 1'b1;
      tick(40);
      check(!fifo_cs && done, "R11", "edge after done", fifo_cs, 0);
      hf = 1'b0;
      tick(10);
      // R1 restart
      pulse_start();
      tick(2);
      check(!done, "R1", "done cleared by start", done, 0);
      check(buf_addr == BASE, "R1", "address rebased", buf_addr, BASE);
      hf = 1'b1;
      wait_writes(int'(BLEN));
      tick(40);
      check(fifo_cs && wr_total > int'(BLEN), "R4", "restart continues", wr_total, BLEN + 1);
      check(fifo_addr == LOC, "R10", "fifo_addr at end", fifo_addr, LOC);
      finish_run();
   end

endmodule